// File: doc/BRIEF.md
# Page Protection and Fault Encoder

This block takes the outcome of an address translation attempt and turns it into an access decision. Its inputs are the protection fields of a matched page entry, the access key, the segment no-execute flag, the access type, the two translation-enable bits and a lookup result. Its outputs are the granted permission set, a pass flag and, when the access is refused, an exception class with the syndrome word that goes with it. The page-table walk and the segment lookup run upstream. Exception vectoring runs downstream.

A request is presented with `req_valid` high for one cycle. On the next clock edge the result is registered and `rsp_valid` pulses. Between requests all result outputs hold their last values. When translation is disabled for the access type, the block takes the real-mode path: the effective address comes out with its top bits cleared and every permission is granted.

Top module: `pgprot_fault_unit`

## Requirements
- R1: The protection code is {`pte_pp0`, `pte_pp[1:0]`}. With `pte_key`=0, codes 0, 1 and 2 grant read and write, codes 3 and 6 grant read only, and codes 4, 5 and 7 grant neither.
- R2: With `pte_key`=1, codes 1 and 3 grant read only and code 2 grants read and write. Codes 0, 4, 5, 6 and 7 grant neither read nor write.
- R3: For a found page, execute (`perm_x`) is granted exactly when both `pte_noexec` and `pte_guard` are 0.
- R4: Access type encoding is 0 = load, 1 = store, 2 = fetch (3 acts as a load). A found page passes only when the granted set holds read for a load, write for a store, or execute for a fetch.
- R5: Real mode applies when a fetch has `xlate_instr`=0 or a load/store has `xlate_data`=0. In that case `real_addr` equals `eff_addr` with its top 4 bits zeroed, `real_mode`=1, all three permissions are 1, `pass`=1 and `exc_class`=0. The lookup and entry inputs are then ignored. Outside real mode `real_addr` is 0.
- R6: A translated fetch with `lookup_res`≠0 and `seg_noexec`=1 fails with `exc_class`=1 and `ifault_code`=0x10000000, whatever the page result.
- R7: `lookup_res` encoding is 0 = segment miss, 1 = page miss, 2 = found (3 acts as page miss). A segment miss gives `exc_class`=2 for a fetch or 4 for a load/store, with zero codes. A data segment miss puts `eff_addr` on `fault_addr`.
- R8: A fetch page miss gives `exc_class`=1 with code 0x40000000. A fetch permission failure gives `exc_class`=1 with code 0x08000000.
- R9: Data faults give `exc_class`=3. `dstatus` is 0x42000000 for a store page miss, 0x40000000 for a load page miss, 0x0A000000 for a store permission failure and 0x08000000 for a load permission failure. `fault_addr` equals `eff_addr` on every data fault and is 0 otherwise.
- R10: Each failure grants no permissions, except a permission failure on a found page, which reports the set from R1–R3. A pass always carries `exc_class`=0 and zero codes.
- R11: Outputs register on the clock edge after `req_valid`=1, and `rsp_valid` is high for that one cycle. When `req_valid`=0, the result outputs hold.
- R12: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch |
| xlate_instr | input | 1 | Instruction translation enable |
| xlate_data | input | 1 | Data translation enable |
| lookup_res | input | 2 | 0 segment miss, 1 page miss, 2 found |
| seg_noexec | input | 1 | Segment no-execute flag |
| pte_pp | input | 2 | Low protection bits of the entry |
| pte_pp0 | input | 1 | High protection bit of the entry |
| pte_key | input | 1 | Selected access key |
| pte_noexec | input | 1 | Entry no-execute bit |
| pte_guard | input | 1 | Entry guarded bit |
| eff_addr | input | ADDR_W | Effective address |
| rsp_valid | output | 1 | Result strobe |
| perm_r | output | 1 | Read granted |
| perm_w | output | 1 | Write granted |
| perm_x | output | 1 | Execute granted |
| pass | output | 1 | Access allowed |
| exc_class | output | 3 | 0 none, 1 instr storage, 2 instr segment, 3 data storage, 4 data segment |
| ifault_code | output | 32 | Instruction fault error code |
| dstatus | output | 32 | Data fault status word |
| fault_addr | output | ADDR_W | Captured data fault address |
| real_addr | output | ADDR_W | Real-mode output address |
| real_mode | output | 1 | Real-mode path taken |

## Verification
The protection table is swept over all eight codes, both keys and all four combinations of no-execute and guarded, once for each access type. This separates the key-0 rows from the key-1 rows, checks that the undefined codes grant nothing, and confirms that execute depends only on the two entry bits. Fault tests pair each lookup result with load, store and fetch, which separates the four data status words from the instruction codes. Further cases cover segment no-execute against each page result, real mode chosen by each enable bit while the other enable is set, and address stripping with all-ones and patterned addresses. Idle cycles with changed inputs confirm that results hold between requests.

// File: rtl/pgprot_pkg.sv
package pgprot_pkg;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  localparam logic [1:0] LK_SEG_MISS  = 2'd0;
  localparam logic [1:0] LK_PAGE_MISS = 2'd1;
  localparam logic [1:0] LK_FOUND     = 2'd2;

  localparam logic [2:0] EXC_NONE   = 3'd0;
  localparam logic [2:0] EXC_ISTOR  = 3'd1;
  localparam logic [2:0] EXC_ISEG   = 3'd2;
  localparam logic [2:0] EXC_DSTOR  = 3'd3;
  localparam logic [2:0] EXC_DSEG   = 3'd4;

  localparam int unsigned CODE_W = 32;

  localparam logic [CODE_W-1:0] IC_NOPAGE  = 32'h4000_0000;
  localparam logic [CODE_W-1:0] IC_PROT    = 32'h0800_0000;
  localparam logic [CODE_W-1:0] IC_SEGNX   = 32'h1000_0000;
  localparam logic [CODE_W-1:0] DS_NOPAGE  = 32'h4000_0000;
  localparam logic [CODE_W-1:0] DS_PROT    = 32'h0800_0000;
  localparam logic [CODE_W-1:0] DS_STORE   = 32'h0200_0000;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;

  typedef struct packed {
    perm_t             perm;
    logic              pass;
    logic [2:0]        exc;
    logic [CODE_W-1:0] icode;
    logic [CODE_W-1:0] dstat;
    logic              dfault;
    logic              realm;
  } verdict_t;

endpackage

// File: rtl/pgprot_perm_decode.sv
module pgprot_perm_decode
  import pgprot_pkg::*;
(
  input  logic [2:0] code,
  input  logic       key,
  input  logic       noexec,
  input  logic       guard,
  output perm_t      perm
);

  logic rd_k0, wr_k0, rd_k1, wr_k1;

  always_comb begin
    rd_k0 = 1'b0;
    wr_k0 = 1'b0;
    unique case (code)
      3'd0, 3'd1, 3'd2: begin rd_k0 = 1'b1; wr_k0 = 1'b1; end
      3'd3, 3'd6:       rd_k0 = 1'b1;
      default:          ;
    endcase
  end

  always_comb begin
    rd_k1 = 1'b0;
    wr_k1 = 1'b0;
    unique case (code)
      3'd1, 3'd3: rd_k1 = 1'b1;
      3'd2:       begin rd_k1 = 1'b1; wr_k1 = 1'b1; end
      default:    ;
    endcase
  end

  always_comb begin
    perm.r = key ? rd_k1 : rd_k0;
    perm.w = key ? wr_k1 : wr_k0;
    perm.x = ~(noexec | guard);
  end

  always_comb begin
    if (code == 3'd4 || code == 3'd5 || code == 3'd7)
      AST_UNDEF_EMPTY: assert (!perm.r && !perm.w); // R1
    if (perm.w)
      AST_WRITE_IMPLIES_READ: assert (perm.r); // R2
  end

endmodule

// File: rtl/pgprot_fault_encode.sv
module pgprot_fault_encode
  import pgprot_pkg::*;
(
  input  logic [1:0] acc_type,
  input  logic       xlate_instr,
  input  logic       xlate_data,
  input  logic [1:0] lookup_res,
  input  logic       seg_noexec,
  input  perm_t      tbl,
  output verdict_t   vd
);

  logic is_fetch, is_store, xlate_on, allowed;

  always_comb begin
    is_fetch = (acc_type == ACC_FETCH);
    is_store = (acc_type == ACC_STORE);
    xlate_on = is_fetch ? xlate_instr : xlate_data;
    allowed  = is_fetch ? tbl.x : (is_store ? tbl.w : tbl.r);
  end

  always_comb begin
    vd = '0;
    if (!xlate_on) begin
      vd.realm = 1'b1;
      vd.pass  = 1'b1;
      vd.perm  = '{r: 1'b1, w: 1'b1, x: 1'b1};
    end else if (lookup_res == LK_SEG_MISS) begin
      vd.exc    = is_fetch ? EXC_ISEG : EXC_DSEG;
      vd.dfault = ~is_fetch;
    end else if (is_fetch && seg_noexec) begin
      vd.exc   = EXC_ISTOR;
      vd.icode = IC_SEGNX;
    end else if (lookup_res != LK_FOUND) begin
      if (is_fetch) begin
        vd.exc   = EXC_ISTOR;
        vd.icode = IC_NOPAGE;
      end else begin
        vd.exc    = EXC_DSTOR;
        vd.dstat  = DS_NOPAGE | (is_store ? DS_STORE : '0);
        vd.dfault = 1'b1;
      end
    end else begin
      vd.perm = tbl;
      if (allowed) begin
        vd.pass = 1'b1;
      end else if (is_fetch) begin
        vd.exc   = EXC_ISTOR;
        vd.icode = IC_PROT;
      end else begin
        vd.exc    = EXC_DSTOR;
        vd.dstat  = DS_PROT | (is_store ? DS_STORE : '0);
        vd.dfault = 1'b1;
      end
    end
  end

  always_comb begin
    if (!xlate_on)
      AST_REAL_GRANTS: assert (vd.pass && vd.exc == EXC_NONE); // R5
    if (is_fetch)
      AST_FETCH_NO_DSTAT: assert (vd.dstat == '0 && !vd.dfault); // R8
    else
      AST_DATA_NO_ICODE: assert (vd.icode == '0); // R9
  end

endmodule

// File: rtl/pgprot_fault_unit.sv
module pgprot_fault_unit
  import pgprot_pkg::*;
#(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned STRIP_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        acc_type,
  input  logic              xlate_instr,
  input  logic              xlate_data,
  input  logic [1:0]        lookup_res,
  input  logic              seg_noexec,
  input  logic [1:0]        pte_pp,
  input  logic              pte_pp0,
  input  logic              pte_key,
  input  logic              pte_noexec,
  input  logic              pte_guard,
  input  logic [ADDR_W-1:0] eff_addr,
  output logic              rsp_valid,
  output logic              perm_r,
  output logic              perm_w,
  output logic              perm_x,
  output logic              pass,
  output logic [2:0]        exc_class,
  output logic [31:0]       ifault_code,
  output logic [31:0]       dstatus,
  output logic [ADDR_W-1:0] fault_addr,
  output logic [ADDR_W-1:0] real_addr,
  output logic              real_mode
);

  localparam int unsigned KEEP_W = ADDR_W - STRIP_BITS;
  localparam logic [ADDR_W-1:0] KEEP_MASK = {{STRIP_BITS{1'b0}}, {KEEP_W{1'b1}}};

  perm_t    tbl_perm;
  verdict_t vd;

  pgprot_perm_decode u_decode (
    .code   ({pte_pp0, pte_pp}),
    .key    (pte_key),
    .noexec (pte_noexec),
    .guard  (pte_guard),
    .perm   (tbl_perm)
  );

  pgprot_fault_encode u_encode (
    .acc_type    (acc_type),
    .xlate_instr (xlate_instr),
    .xlate_data  (xlate_data),
    .lookup_res  (lookup_res),
    .seg_noexec  (seg_noexec),
    .tbl         (tbl_perm),
    .vd          (vd)
  );

  verdict_t          vd_q, vd_d;
  logic [ADDR_W-1:0] faddr_q, faddr_d;
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic              vld_q;

  always_comb begin
    vd_d    = vd_q;
    faddr_d = faddr_q;
    raddr_d = raddr_q;
    if (req_valid) begin
      vd_d    = vd;
      faddr_d = vd.dfault ? eff_addr : '0;
      raddr_d = vd.realm ? (eff_addr & KEEP_MASK) : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vd_q    <= '0;
      faddr_q <= '0;
      raddr_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      vd_q    <= vd_d;
      faddr_q <= faddr_d;
      raddr_q <= raddr_d;
      vld_q   <= req_valid;
    end
  end

  always_comb begin
    rsp_valid   = vld_q;
    perm_r      = vd_q.perm.r;
    perm_w      = vd_q.perm.w;
    perm_x      = vd_q.perm.x;
    pass        = vd_q.pass;
    exc_class   = vd_q.exc;
    ifault_code = vd_q.icode;
    dstatus     = vd_q.dstat;
    fault_addr  = faddr_q;
    real_addr   = raddr_q;
    real_mode   = vd_q.realm;
  end

  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(exc_class) && $stable(pass) && $stable(fault_addr)); // R11
  AST_PASS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> exc_class == EXC_NONE && ifault_code == '0 && dstatus == '0); // R10
  AST_REAL_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    real_mode |-> real_addr[ADDR_W-1:KEEP_W] == '0 && perm_r && perm_w && perm_x); // R5
  AST_SEG_FAULT_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_class == EXC_ISEG || exc_class == EXC_DSEG) |-> ifault_code == '0 && dstatus == '0); // R7

endmodule

// File: tb/pgprot_fault_unit_test.sv
module pgprot_fault_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 64;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [1:0]    acc_type;
  logic          xlate_instr, xlate_data;
  logic [1:0]    lookup_res;
  logic          seg_noexec;
  logic [1:0]    pte_pp;
  logic          pte_pp0, pte_key, pte_noexec, pte_guard;
  logic [AW-1:0] eff_addr;
  logic          rsp_valid, perm_r, perm_w, perm_x, pass, real_mode;
  logic [2:0]    exc_class;
  logic [31:0]   ifault_code, dstatus;
  logic [AW-1:0] fault_addr, real_addr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgprot_fault_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_type(acc_type),
    .xlate_instr(xlate_instr), .xlate_data(xlate_data), .lookup_res(lookup_res),
    .seg_noexec(seg_noexec), .pte_pp(pte_pp), .pte_pp0(pte_pp0), .pte_key(pte_key),
    .pte_noexec(pte_noexec), .pte_guard(pte_guard), .eff_addr(eff_addr),
    .rsp_valid(rsp_valid), .perm_r(perm_r), .perm_w(perm_w), .perm_x(perm_x),
    .pass(pass), .exc_class(exc_class), .ifault_code(ifault_code), .dstatus(dstatus),
    .fault_addr(fault_addr), .real_addr(real_addr), .real_mode(real_mode)
  );

  task automatic check(input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Expected read/write from the protection rules (R1 key 0, R2 key 1)
  function automatic logic [1:0] exp_rw(input int code, input logic key);
    if (!key) begin
      if (code <= 2) return 2'b11;
      if (code == 3 || code == 6) return 2'b10;
      return 2'b00;
    end
    if (code == 2) return 2'b11;
    if (code == 1 || code == 3) return 2'b10;
    return 2'b00;
  endfunction

  task automatic issue(input logic [1:0] acc, input logic xi, input logic xd,
                       input logic [1:0] lk, input logic snx, input int code,
                       input logic key, input logic nx, input logic g,
                       input logic [AW-1:0] ea);
    @(negedge clk);
    acc_type = acc; xlate_instr = xi; xlate_data = xd; lookup_res = lk;
    seg_noexec = snx; pte_pp = code[1:0]; pte_pp0 = code[2]; pte_key = key;
    pte_noexec = nx; pte_guard = g; eff_addr = ea; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R12", "rsp_valid", rsp_valid, 0);
    check("R12", "perm", {perm_r, perm_w, perm_x}, 0);
    check("R12", "pass", pass, 0);
    check("R12", "exc", exc_class, 0);
    check("R12", "codes", {ifault_code, dstatus}, 0);
    check("R12", "addrs", fault_addr | real_addr, 0);
    check("R12", "real_mode", real_mode, 0);
  endtask

  task automatic t_table_sweep();
    for (int acc = 0; acc < 3; acc++)
      for (int key = 0; key < 2; key++)
        for (int code = 0; code < 8; code++)
          for (int ng = 0; ng < 4; ng++) begin
            logic [1:0] rw;
            logic xe, ok;
            rw = exp_rw(code, key[0]);
            xe = (ng == 0);
            ok = (acc == 0) ? rw[1] : (acc == 1) ? rw[0] : xe;
            issue(acc[1:0], 1'b1, 1'b1, 2'd2, 1'b0, code, key[0], ng[0], ng[1], 64'h1234);
            check(key ? "R2" : "R1", "perm rw", {perm_r, perm_w}, rw);
            check("R3", "perm_x", perm_x, xe);
            check("R4", "pass", pass, ok);
            if (!ok) begin
              if (acc == 2) begin
                check("R8", "exc", exc_class, 1);
                check("R8", "icode", ifault_code, 32'h0800_0000);
              end else begin
                check("R9", "exc", exc_class, 3);
                check("R9", "dstatus", dstatus, acc == 1 ? 32'h0A00_0000 : 32'h0800_0000);
                check("R9", "fault_addr", fault_addr, 64'h1234);
              end
            end else begin
              check("R10", "exc on pass", exc_class, 0);
              check("R9", "fault_addr on pass", fault_addr, 0);
            end
          end
  endtask

  task automatic t_page_miss();
    for (int acc = 0; acc < 3; acc++)
      for (int lk = 1; lk < 4; lk += 2) begin
        if (lk == 3 && acc != 1) continue;
        issue(acc[1:0], 1'b1, 1'b1, lk[1:0], 1'b0, 0, 1'b0, 1'b0, 1'b0, 64'hBEEF_0000_0000_1000);
        check("R10", "perm miss", {perm_r, perm_w, perm_x}, 0);
        check("R10", "pass miss", pass, 0);
        if (acc == 2) begin
          check("R8", "exc", exc_class, 1);
          check("R8", "icode", ifault_code, 32'h4000_0000);
          check("R8", "fault_addr", fault_addr, 0);
        end else begin
          check("R9", "exc", exc_class, 3);
          check("R9", "dstatus", dstatus, acc == 1 ? 32'h4200_0000 : 32'h4000_0000);
          check("R9", "fault_addr", fault_addr, 64'hBEEF_0000_0000_1000);
        end
      end
  endtask

  task automatic t_seg_miss();
    for (int acc = 0; acc < 3; acc++) begin
      issue(acc[1:0], 1'b1, 1'b1, 2'd0, 1'b1, 0, 1'b0, 1'b0, 1'b0, 64'h0F0F_AAAA_5555_0000);
      check("R7", "exc", exc_class, acc == 2 ? 3'd2 : 3'd4);
      check("R7", "codes", {ifault_code, dstatus}, 0);
      check("R7", "fault_addr", fault_addr, acc == 2 ? 64'd0 : 64'h0F0F_AAAA_5555_0000);
      check("R10", "perm", {perm_r, perm_w, perm_x}, 0);
    end
  endtask

  task automatic t_seg_noexec();
    for (int lk = 1; lk < 3; lk++) begin
      issue(2'd2, 1'b1, 1'b1, lk[1:0], 1'b1, 0, 1'b0, 1'b0, 1'b0, 64'h40);
      check("R6", "exc", exc_class, 1);
      check("R6", "icode", ifault_code, 32'h1000_0000);
      check("R6", "pass", pass, 0);
    end
    // segment no-execute does not affect a load
    issue(2'd0, 1'b1, 1'b1, 2'd2, 1'b1, 0, 1'b0, 1'b0, 1'b0, 64'h40);
    check("R6", "load ignores seg nx", pass, 1);
  endtask

  task automatic t_real_mode();
    issue(2'd2, 1'b0, 1'b1, 2'd0, 1'b1, 7, 1'b1, 1'b1, 1'b1, '1);
    check("R5", "real fetch pass", pass, 1);
    check("R5", "real_addr", real_addr, 64'h0FFF_FFFF_FFFF_FFFF);
    check("R5", "perm", {perm_r, perm_w, perm_x}, 3'b111);
    check("R5", "real_mode", real_mode, 1);
    check("R5", "exc", exc_class, 0);
    issue(2'd1, 1'b1, 1'b0, 2'd1, 1'b0, 4, 1'b0, 1'b0, 1'b0, 64'hA5A5_1234_5678_9ABC);
    check("R5", "real store pass", pass, 1);
    check("R5", "real_addr", real_addr, 64'h05A5_1234_5678_9ABC);
    check("R5", "fault_addr", fault_addr, 0);
    // instruction enable off does not put a load in real mode
    issue(2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 0, 1'b0, 1'b0, 1'b0, 64'hF000_0000_0000_0010);
    check("R5", "load translated", real_mode, 0);
    check("R7", "dseg", exc_class, 4);
    check("R5", "real_addr zero", real_addr, 0);
    // data enable off does not put a fetch in real mode
    issue(2'd2, 1'b1, 1'b0, 2'd1, 1'b0, 0, 1'b0, 1'b0, 1'b0, 64'h10);
    check("R5", "fetch translated", real_mode, 0);
    check("R8", "fetch miss", ifault_code, 32'h4000_0000);
  endtask

  task automatic t_hold();
    issue(2'd1, 1'b1, 1'b1, 2'd1, 1'b0, 0, 1'b0, 1'b0, 1'b0, 64'h77);
    check("R11", "rsp_valid pulse", rsp_valid, 1);
    @(negedge clk);
    acc_type = 2'd0; xlate_data = 1'b0; eff_addr = 64'h99;
    @(negedge clk);
    check("R11", "rsp_valid low", rsp_valid, 0);
    check("R11", "dstatus held", dstatus, 32'h4200_0000);
    check("R11", "fault_addr held", fault_addr, 64'h77);
    check("R11", "real_mode held", real_mode, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; acc_type = '0; xlate_instr = 1'b1;
    xlate_data = 1'b1; lookup_res = '0; seg_noexec = 1'b0; pte_pp = '0;
    pte_pp0 = 1'b0; pte_key = 1'b0; pte_noexec = 1'b0; pte_guard = 1'b0;
    eff_addr = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_table_sweep();
    t_page_miss();
    t_seg_miss();
    t_seg_noexec();
    t_real_mode();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule